// File: doc/BRIEF.md
# Wake-on-Change Mismatch Detector

This block raises a wake request for a sleeping core when a monitored input differs from the value that firmware last observed. It has two independent channels. The port channel watches selected bits of a general-purpose input port. The comparator channel watches the two comparator output bits. Each channel synchronizes its raw inputs to the system clock with a two-stage flop chain. It keeps a reference register that is reloaded from the synchronized value whenever its read strobe fires. That strobe pulses for every firmware access that reads or modifies the port, or that reads the comparator control registers.

The reference is refreshed on every firmware read, not only at sleep entry. A change that firmware never read back therefore produces a wake request as soon as sleep begins, even if the input does not move again. The request is combinational in the mismatch once the sleep indication is high. It needs no further clock edge, and it drops as soon as sleep ends. The sleep controller consumes `wake_req`. The per-channel outputs tell it which source fired.

Top module: `wake_change_det`

## Requirements
- R1: A synchronous active-high reset clears both reference registers and both synchronizers, so that with all inputs at 0 and sleep and both enables high, all wake outputs are 0 after reset.
- R2: The port channel compares only port bits 0, 1, 3 and 4 of the 6-bit `pin_async` bus (mask 6'b011011). A difference on bit 2 or bit 5 never raises `wake_pin`.
- R3: A one-cycle pulse on a channel's read strobe loads that channel's reference with its current synchronized input. With the input then unchanged, that channel raises no wake.
- R4: While `sleep_act` is high and a channel's enable is high, a difference between that channel's synchronized input and its reference drives its wake output high in the same cycle `sleep_act` rises, without waiting for a clock edge.
- R5: A change that was synchronized but not followed by a read strobe raises the wake output immediately on sleep entry, with no further input change.
- R6: With a channel's wake enable low, that channel's wake output stays 0 whatever the mismatch.
- R7: The comparator channel (2-bit `cmp_async`, both bits monitored) has its own read strobe and enable. A port read strobe does not reload the comparator reference.
- R8: All wake outputs are 0 while `sleep_act` is low and fall in the same cycle `sleep_act` falls.
- R9: An input change reaches the comparison after exactly two rising clock edges. After one edge it has no effect yet.
- R10: `wake_req` is high exactly when `wake_pin` or `wake_cmp` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 6 | Raw port pin levels, not yet synchronized |
| pin_rd_stb | input | 1 | Pulse on each firmware read or modify of the port |
| pin_wake_en | input | 1 | Enables wake on port change |
| cmp_async | input | 2 | Raw comparator output bits |
| cmp_rd_stb | input | 1 | Pulse on each firmware read of the comparator control registers |
| cmp_wake_en | input | 1 | Enables wake on comparator change |
| sleep_act | input | 1 | High while the core is in sleep |
| wake_pin | output | 1 | Wake caused by a port mismatch |
| wake_cmp | output | 1 | Wake caused by a comparator mismatch |
| wake_req | output | 1 | Combined wake request to the sleep controller |

## Verification
The bench goes after the stale-change case: the input moves after the last read and no read follows. A design that captured the reference at sleep entry would stay asleep there. The bench toggles the unmonitored port bits 2 and 5, which a design with a wrong mask would turn into spurious wakes. It also reads only the port while the comparator is stale, which catches a design that shares one strobe between the two channels. Directed checks probe the synchronizer latency, where a one-stage or three-stage chain shifts the wake by a cycle. They also raise and drop sleep between clock edges, which exposes a registered wake output as one cycle late.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

    localparam int PORT_W      = 6;
    localparam logic [PORT_W-1:0] PORT_MASK = 6'b011011;
    localparam int CMP_W       = 2;
    localparam logic [CMP_W-1:0]  CMP_MASK  = 2'b11;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic pin;
        logic cmp;
    } wake_src_t;

    function automatic logic any_wake(input wake_src_t s);
        return s.pin | s.cmp;
    endfunction

endpackage

// File: rtl/wcd_sync.sv
module wcd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chk
            // R9: each stage follows its predecessor by one edge
            a_r9_stage_shift: assert property (@(posedge clk) disable iff (rst)
                stage_q[g] == $past(stage_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/wcd_channel.sv
module wcd_channel #(
    parameter int           W      = 2,
    parameter logic [W-1:0] MASK   = '1,
    parameter int           STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din_async,
    input  logic         rd_stb,
    input  logic         wake_en,
    input  logic         sleep_act,
    output logic         wake_o
);

    logic [W-1:0] live;
    logic [W-1:0] ref_q;
    logic         differs;

    wcd_sync #(.W(W), .STAGES(STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (din_async),
        .q   (live)
    );

    always_ff @(posedge clk) begin
        if (rst)         ref_q <= '0;
        else if (rd_stb) ref_q <= live;
    end

    assign differs = |((live ^ ref_q) & MASK);
    assign wake_o  = sleep_act & wake_en & differs;

    // R3: a read strobe captures the synchronized value
    a_r3_ref_load: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> ref_q == $past(live));
    // R3: without a strobe the reference holds
    a_r3_ref_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(ref_q));
    // R8: no wake while awake
    a_r8_no_wake_awake: assert property (@(posedge clk) disable iff (rst)
        !sleep_act |-> !wake_o);
    // R6: no wake while disabled
    a_r6_no_wake_disabled: assert property (@(posedge clk) disable iff (rst)
        !wake_en |-> !wake_o);

endmodule

// File: rtl/wake_change_det.sv
module wake_change_det
    import wcd_pkg::*;
#(
    parameter int                   P_W    = PORT_W,
    parameter logic [PORT_W-1:0]    P_MASK = PORT_MASK,
    parameter int                   C_W    = CMP_W,
    parameter int                   STAGES = SYNC_STAGES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] pin_async,
    input  logic           pin_rd_stb,
    input  logic           pin_wake_en,
    input  logic [C_W-1:0] cmp_async,
    input  logic           cmp_rd_stb,
    input  logic           cmp_wake_en,
    input  logic           sleep_act,
    output logic           wake_pin,
    output logic           wake_cmp,
    output logic           wake_req
);

    localparam logic [C_W-1:0] C_MASK = '1;

    wake_src_t src;

    wcd_channel #(.W(P_W), .MASK(P_MASK[P_W-1:0]), .STAGES(STAGES)) pin_ch_i (
        .clk       (clk),
        .rst       (rst),
        .din_async (pin_async),
        .rd_stb    (pin_rd_stb),
        .wake_en   (pin_wake_en),
        .sleep_act (sleep_act),
        .wake_o    (src.pin)
    );

    wcd_channel #(.W(C_W), .MASK(C_MASK), .STAGES(STAGES)) cmp_ch_i (
        .clk       (clk),
        .rst       (rst),
        .din_async (cmp_async),
        .rd_stb    (cmp_rd_stb),
        .wake_en   (cmp_wake_en),
        .sleep_act (sleep_act),
        .wake_o    (src.cmp)
    );

    assign wake_pin = src.pin;
    assign wake_cmp = src.cmp;
    assign wake_req = any_wake(src);

    // R8: combined request is low whenever sleep is not active
    a_r8_req_awake: assert property (@(posedge clk) disable iff (rst)
        !sleep_act |-> !wake_req);
    // R10: a request always has a source
    a_r10_req_has_src: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (wake_pin || wake_cmp));

endmodule

// File: tb/wake_change_det_tb_top.sv
`timescale 1ns/1ps
module wake_change_det_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] pin_async;
    logic       pin_rd_stb, pin_wake_en;
    logic [1:0] cmp_async;
    logic       cmp_rd_stb, cmp_wake_en;
    logic       sleep_act;
    logic       wake_pin, wake_cmp, wake_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wake_change_det dut_i (
        .clk(clk), .rst(rst),
        .pin_async(pin_async), .pin_rd_stb(pin_rd_stb), .pin_wake_en(pin_wake_en),
        .cmp_async(cmp_async), .cmp_rd_stb(cmp_rd_stb), .cmp_wake_en(cmp_wake_en),
        .sleep_act(sleep_act),
        .wake_pin(wake_pin), .wake_cmp(wake_cmp), .wake_req(wake_req)
    );

    typedef struct packed {
        logic [5:0] pa;   // port value at read time
        logic [5:0] pb;   // port value while sleeping
        logic [1:0] ca;
        logic [1:0] cb;
        logic       rdp, rdc, enp, enc, slp;
        logic       ep, ec, er;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{6'b000000, 6'b000000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 clean
        '{6'b000000, 6'b000001, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 bit0
        '{6'b000000, 6'b100100, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 bits 2,5
        '{6'b011011, 6'b011011, 2'b10, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 all ones
        '{6'b001000, 6'b001000, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 stale
        '{6'b001000, 6'b001000, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 pin off, R7 cmp
        '{6'b010000, 6'b010000, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 reload
        '{6'b010000, 6'b010000, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 separate strobe
        '{6'b010000, 6'b010000, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 cmp off
        '{6'b000010, 6'b000010, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 awake
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_async = '0; cmp_async = '0;
        pin_rd_stb = 0; cmp_rd_stb = 0; pin_wake_en = 1; cmp_wake_en = 1; sleep_act = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 wake_pin after reset", wake_pin, 1'b0);
        chk("R1 wake_cmp after reset", wake_cmp, 1'b0);
        chk("R1 wake_req after reset", wake_req, 1'b0);
        sleep_act = 0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pin_async = VEC[v].pa; cmp_async = VEC[v].ca; sleep_act = 0;
            repeat (3) @(negedge clk);
            pin_rd_stb = VEC[v].rdp; cmp_rd_stb = VEC[v].rdc;
            @(negedge clk);
            pin_rd_stb = 0; cmp_rd_stb = 0;
            pin_async = VEC[v].pb; cmp_async = VEC[v].cb;
            repeat (3) @(negedge clk);
            pin_wake_en = VEC[v].enp; cmp_wake_en = VEC[v].enc; sleep_act = VEC[v].slp;
            #1;
            chk($sformatf("vec %0d wake_pin (R2 R3 R4 R5 R6 R8)", v), wake_pin, VEC[v].ep);
            chk($sformatf("vec %0d wake_cmp (R6 R7)", v), wake_cmp, VEC[v].ec);
            chk($sformatf("vec %0d wake_req (R10)", v), wake_req, VEC[v].er);
        end

        // R9: synchronizer latency, starting from clean references
        @(negedge clk);
        sleep_act = 0; pin_wake_en = 1; cmp_wake_en = 1;
        pin_async = 6'b000000; cmp_async = 2'b01;
        repeat (3) @(negedge clk);
        pin_rd_stb = 1; cmp_rd_stb = 1;
        @(negedge clk);
        pin_rd_stb = 0; cmp_rd_stb = 0;
        sleep_act = 1;
        #1;
        chk("R3 clean after both reads", wake_req, 1'b0);
        @(negedge clk);
        pin_async = 6'b000010;
        @(negedge clk);
        #1;
        chk("R9 no wake after one edge", wake_pin, 1'b0);
        @(negedge clk);
        #1;
        chk("R9 wake after two edges", wake_pin, 1'b1);

        // R8: drop between edges
        sleep_act = 0;
        #1;
        chk("R8 wake_req falls with sleep", wake_req, 1'b0);
        // R4: rise between edges
        sleep_act = 1;
        #1;
        chk("R4 wake_req rises with sleep, no edge", wake_req, 1'b1);
        chk("R10 wake_req follows wake_pin", wake_req, wake_pin | wake_cmp);

        @(negedge clk);
        sleep_act = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule